// File: doc/BRIEF.md
# Timer Counter with Shared Prescaler and Watchdog

This block is an 8-bit event counter and a watchdog. They share a single 8-bit prescaler and are set up through one 8-bit mode register. The counter advances either on every instruction cycle (every clock) or on a chosen edge of an external pin. The pin passes through a synchronizer before its edges are detected. The watchdog counts a separate tick input. When its count completes, it issues a one-cycle reset pulse and drops a health flag. A clear-watchdog strobe or a sleep strobe restarts the watchdog and raises the flag again.

The prescaler serves whichever side the mode register assigns it to. The same three ratio bits give the counter twice the division they give the watchdog. The side that does not own the prescaler runs undivided. Software reads the counter through `cnt_value` and loads it with `cnt_wr`. Nothing in this block carries a data stream, so every pin is a plain level or a one-cycle strobe with no handshake.

Top module: `tick_timer_wdt`

## Requirements
- R1: After reset, `cnt_value` is 0, `wdt_reset` is 0, `wdt_ok_flag` is 1 and the mode register holds all ones. With that mode, the counter takes its events from the pin on falling edges, the prescaler belongs to the watchdog, and the watchdog is disabled (unless forced on).
- R2: A `mode_wr` strobe loads `mode_wdata` at the clock edge. The fields are: bits [2:0] ratio code, bit 3 prescaler owner (0 counter, 1 watchdog), bit 4 pin polarity (0 rising, 1 falling), bit 5 counter source (0 every clock, 1 pin), bit 7 watchdog off (0 enables it). Bit 6 has no effect.
- R3: When the counter owns the prescaler, it advances once per 2^(code+1) source events. Codes 0 through 7 therefore give 2 to 256.
- R4: When the watchdog owns the prescaler, the counter advances on every source event. The watchdog then sees one base tick per 2^code `wdt_tick` pulses, which gives 1 to 128.
- R5: With source bit 0, every clock cycle is a source event.
- R6: With source bit 1, a source event is a rising (bit 4 = 0) or falling (bit 4 = 1) transition of `ext_pin` after a two-flop synchronizer. The other polarity is ignored.
- R7: `cnt_wr` loads `cnt_wdata` into the counter and clears the prescaler. The load takes precedence over a coincident increment. The counter wraps from FFh to 00h.
- R8: An enabled watchdog issues a `wdt_reset` pulse exactly one cycle wide after 256 base ticks. At the same time it drives `wdt_ok_flag` to 0, and it then starts over.
- R9: `clr_wdt` or `sleep_req` zeroes the watchdog count and sets `wdt_ok_flag` to 1. When the watchdog owns the prescaler, either strobe also clears the prescaler.
- R10: A disabled watchdog holds its count at zero and never pulses. When parameter `WDT_ALWAYS_ON` is 1, the watchdog runs whatever the value of mode bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| cnt_value | output | 8 | Current counter value |
| ext_pin | input | 1 | Asynchronous external count pin |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| sleep_req | input | 1 | Sleep-entry strobe (also clears the watchdog) |
| wdt_tick | input | 1 | Watchdog base tick strobe |
| wdt_reset | output | 1 | One-cycle watchdog timeout pulse |
| wdt_ok_flag | output | 1 | 1 until a timeout occurs; set again by a clear or sleep |

## Verification
The hardest state to reach is a watchdog timeout behind a large prescaler ratio. It takes 256 times 2^code ticks with no intervening clear, and it has to land exactly on the predicted edge. The bench builds this up in two ways. It holds `wdt_tick` high for long stretches under ratio codes 0 and 2, with directed checks one tick before and on the expiring tick. It also runs a second instance with the watchdog forced on while the main instance has it disabled. A pseudo-random phase then mixes mode rewrites, counter loads, clears and pin toggles, so that ownership changes while the prescaler is partly filled. A behavioural model tracks all of it on every clock.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int MODE_W = 8;

  typedef struct packed {
    logic       wdt_off;    // bit 7
    logic       spare;      // bit 6
    logic       src_pin;    // bit 5
    logic       edge_fall;  // bit 4
    logic       pre_to_wdt; // bit 3
    logic [2:0] ratio;      // bits 2..0
  } mode_t;

  localparam mode_t MODE_RST = mode_t'({MODE_W{1'b1}});
endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_fall,
  output logic evt
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-1:0], pin};
  end

  logic cur, prev;
  assign cur  = sync_q[STAGES-1];
  assign prev = sync_q[STAGES];
  assign evt  = edge_fall ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/shared_prescaler.sv
module shared_prescaler #(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv,
  input  logic [2:0] ratio,
  input  logic       to_wdt,
  output logic       tap
);
  localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

  logic [W-1:0] pre_q;
  logic [3:0]   shamt;
  logic [W:0]   span;
  logic [W-1:0] mask;

  // watchdog owner divides by 2^code, counter owner by 2^(code+1)
  assign shamt = to_wdt ? {1'b0, ratio} : ({1'b0, ratio} + 4'd1);
  assign span  = (ONE << shamt) - ONE;
  assign mask  = span[W-1:0];
  assign tap   = adv && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (adv) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic tick,
  output logic rst_pulse,
  output logic ok_flag
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rst_pulse <= 1'b0;
      ok_flag   <= 1'b1;
    end else begin
      rst_pulse <= 1'b0;
      if (clr) begin
        cnt_q   <= '0;
        ok_flag <= 1'b1;
      end else if (!en) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == LAST) begin
          cnt_q     <= '0;
          rst_pulse <= 1'b1;
          ok_flag   <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tick_timer_wdt.sv
module tick_timer_wdt
  import tick_timer_pkg::*;
#(
  parameter int       CNT_W         = 8,
  parameter int       PRE_W         = 8,
  parameter int       WD_W          = 8,
  parameter int       SYNC_STAGES   = 2,
  parameter bit       WDT_ALWAYS_ON = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_value,
  input  logic              ext_pin,
  input  logic              clr_wdt,
  input  logic              sleep_req,
  input  logic              wdt_tick,
  output logic              wdt_reset,
  output logic              wdt_ok_flag
);
  mode_t mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= MODE_RST;
    else if (mode_wr) mode_q <= mode_t'(mode_wdata);
  end

  logic pin_evt, src_evt, pre_adv, pre_clr, pre_tap;
  logic cnt_inc, wd_tick, wd_clr, wd_en;

  pin_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .edge_fall(mode_q.edge_fall), .evt(pin_evt)
  );

  assign src_evt = mode_q.src_pin ? pin_evt : 1'b1;
  assign wd_clr  = clr_wdt | sleep_req;
  assign pre_adv = mode_q.pre_to_wdt ? wdt_tick : src_evt;
  assign pre_clr = cnt_wr | (mode_q.pre_to_wdt & wd_clr);

  shared_prescaler #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(pre_clr), .adv(pre_adv),
    .ratio(mode_q.ratio), .to_wdt(mode_q.pre_to_wdt), .tap(pre_tap)
  );

  assign cnt_inc = mode_q.pre_to_wdt ? src_evt : pre_tap;
  assign wd_tick = mode_q.pre_to_wdt ? pre_tap : wdt_tick;
  assign wd_en   = WDT_ALWAYS_ON | ~mode_q.wdt_off;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_value <= '0;
    else if (cnt_wr)  cnt_value <= cnt_wdata;
    else if (cnt_inc) cnt_value <= cnt_value + 1'b1;
  end

  wdog_counter #(.W(WD_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .en(wd_en), .clr(wd_clr), .tick(wd_tick),
    .rst_pulse(wdt_reset), .ok_flag(wdt_ok_flag)
  );
endmodule

// File: rtl/tick_timer_wdt_chk.sv
module tick_timer_wdt_chk #(
  parameter int CNT_W = 8,
  parameter bit FORCE = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_value,
  input logic             clr_wdt,
  input logic             sleep_req,
  input logic             wdt_reset,
  input logic             wdt_ok_flag,
  input logic             wdt_off
);
  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);

  assert_flag_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> !wdt_ok_flag);

  assert_clear_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wdt || sleep_req) |=> (wdt_ok_flag && !wdt_reset));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_value == $past(cnt_wdata)));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_value == $past(cnt_value) ||
                 cnt_value == $past(cnt_value) + 1'b1));

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_off && !FORCE) |=> !wdt_reset);
endmodule

bind tick_timer_wdt tick_timer_wdt_chk #(.CNT_W(CNT_W), .FORCE(WDT_ALWAYS_ON)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .cnt_value(cnt_value), .clr_wdt(clr_wdt), .sleep_req(sleep_req),
  .wdt_reset(wdt_reset), .wdt_ok_flag(wdt_ok_flag), .wdt_off(mode_q.wdt_off)
);

// File: tb/tb_tick_timer_wdt.sv
module tb_tick_timer_wdt;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       mode_wr = 0, cnt_wr = 0, ext_pin = 0, clr_wdt = 0, sleep_req = 0, wdt_tick = 0;
  logic [7:0] mode_wdata = 0, cnt_wdata = 0;
  logic [7:0] cnt_value, cnt_value_f;
  logic       wdt_reset, wdt_ok_flag, wdt_reset_f, wdt_ok_flag_f;

  tick_timer_wdt dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_value(cnt_value),
    .ext_pin(ext_pin), .clr_wdt(clr_wdt), .sleep_req(sleep_req),
    .wdt_tick(wdt_tick), .wdt_reset(wdt_reset), .wdt_ok_flag(wdt_ok_flag)
  );

  tick_timer_wdt #(.WDT_ALWAYS_ON(1'b1)) dut_force (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_value(cnt_value_f),
    .ext_pin(ext_pin), .clr_wdt(clr_wdt), .sleep_req(sleep_req),
    .wdt_tick(wdt_tick), .wdt_reset(wdt_reset_f), .wdt_ok_flag(wdt_ok_flag_f)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mode, m_cnt, m_pre;
  int hist[$];
  int m_wd[2], m_fl[2], m_pl[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 255; m_cnt = 0; m_pre = 0;
      hist = '{0, 0, 0};
      for (int k = 0; k < 2; k++) begin m_wd[k] = 0; m_fl[k] = 1; m_pl[k] = 0; end
    end else begin
      int sel, div, ev, adv, tap, inc, wtk, rising, falling;
      bit owner_wdt;
      sel = m_mode % 8;
      owner_wdt = ((m_mode >> 3) & 1) == 1;
      rising  = (hist[1] == 1 && hist[2] == 0);
      falling = (hist[1] == 0 && hist[2] == 1);
      if (((m_mode >> 5) & 1) == 1) ev = (((m_mode >> 4) & 1) == 1) ? falling : rising;
      else ev = 1;
      div = owner_wdt ? (1 << sel) : (2 << sel);
      adv = owner_wdt ? int'(wdt_tick) : ev;
      tap = adv && (((m_pre + 1) % div) == 0);
      inc = owner_wdt ? ev : tap;
      wtk = owner_wdt ? tap : int'(wdt_tick);
      if (cnt_wr || (owner_wdt && (clr_wdt || sleep_req))) m_pre = 0;
      else if (adv) m_pre = (m_pre + 1) % 256;
      if (cnt_wr) m_cnt = cnt_wdata;
      else if (inc) m_cnt = (m_cnt + 1) % 256;
      for (int k = 0; k < 2; k++) begin
        bit en;
        en = (k == 1) || (((m_mode >> 7) & 1) == 0);
        m_pl[k] = 0;
        if (clr_wdt || sleep_req) begin m_wd[k] = 0; m_fl[k] = 1; end
        else if (!en) m_wd[k] = 0;
        else if (wtk) begin
          if (m_wd[k] == 255) begin m_wd[k] = 0; m_pl[k] = 1; m_fl[k] = 0; end
          else m_wd[k]++;
        end
      end
      if (mode_wr) m_mode = mode_wdata;
      hist.push_front(int'(ext_pin));
      void'(hist.pop_back());
    end
  end

  int pulses0 = 0, pulses1 = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, cnt_value,   m_cnt,   "cnt_value");
      check(cur_req, wdt_reset,   m_pl[0], "wdt_reset");
      check(cur_req, wdt_ok_flag, m_fl[0], "wdt_ok_flag");
      check(cur_req, wdt_reset_f, m_pl[1], "forced wdt_reset");
      check(cur_req, wdt_ok_flag_f, m_fl[1], "forced wdt_ok_flag");
      pulses0 += int'(wdt_reset);
      pulses1 += int'(wdt_reset_f);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_mode(input logic [7:0] m);
    mode_wr = 1; mode_wdata = m; cyc(1); mode_wr = 0;
  endtask
  task automatic load_cnt(input logic [7:0] v);
    cnt_wr = 1; cnt_wdata = v; cyc(1); cnt_wr = 0;
  endtask
  task automatic pulse_clr(input bit use_sleep);
    if (use_sleep) sleep_req = 1; else clr_wdt = 1;
    cyc(1); sleep_req = 0; clr_wdt = 0;
  endtask
  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1; cyc(3); ext_pin = 0; cyc(3);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    cyc(3);
    // R1: reset state
    check("R1", cnt_value, 0, "reset cnt_value");
    check("R1", wdt_reset, 0, "reset wdt_reset");
    check("R1", wdt_ok_flag, 1, "reset wdt_ok_flag");
    rst_n = 1;
    wdt_tick = 1; cyc(40); wdt_tick = 0;
    // R1: all-ones mode -> pin source, watchdog off
    check("R1", cnt_value, 0, "no count with pin source");
    check("R1", pulses0, 0, "watchdog off after reset");

    // R3 / R5: prescaler to counter, clock source, each ratio code
    cur_req = "R3";
    for (int s = 0; s < 8; s++) begin
      set_mode(8'h80 | 8'(s));
      load_cnt(8'h00);
      cyc(3 * (2 << s));
      check("R3", cnt_value, 3, "count after 3 prescaled periods");
    end

    // R4 / R5 / R7: prescaler to watchdog, counter every clock, wrap
    cur_req = "R4";
    set_mode(8'h88);
    load_cnt(8'hFE);
    cyc(3);
    check("R7", cnt_value, 1, "wrap FE->01 in 3 clocks");
    cur_req = "R7";
    load_cnt(8'h40);
    check("R7", cnt_value, 8'h40, "load wins over increment");
    cyc(1);
    check("R5", cnt_value, 8'h41, "increment every clock");

    // R6: pin source, both polarities; bit 6 irrelevant (R2)
    cur_req = "R6";
    set_mode(8'hE8);
    load_cnt(8'h00);
    pin_pulses(5); cyc(4);
    check("R6", cnt_value, 5, "rising edges counted");
    set_mode(8'hB8);
    load_cnt(8'h00);
    pin_pulses(4); cyc(4);
    check("R6", cnt_value, 4, "falling edges counted");

    // R8: 1:1 watchdog, timeout on 256th tick
    cur_req = "R8";
    set_mode(8'h08);
    pulse_clr(0);
    pulses0 = 0;
    wdt_tick = 1; cyc(255);
    check("R8", pulses0, 0, "no pulse before 256 ticks");
    check("R8", wdt_ok_flag, 1, "flag high before timeout");
    cyc(1);
    check("R8", wdt_reset, 1, "pulse on 256th tick");
    check("R8", wdt_ok_flag, 0, "flag dropped on timeout");
    wdt_tick = 0; cyc(1);
    check("R8", wdt_reset, 0, "pulse one cycle wide");

    // R9: sleep restarts watchdog and restores flag
    cur_req = "R9";
    wdt_tick = 1; cyc(200); wdt_tick = 0;
    pulse_clr(1);
    check("R9", wdt_ok_flag, 1, "sleep sets flag");
    pulses0 = 0;
    wdt_tick = 1; cyc(255); wdt_tick = 0; cyc(2);
    check("R9", pulses0, 0, "count restarted by sleep");

    // R4 / R2: watchdog ratio 1:4 -> 1024 ticks
    cur_req = "R4";
    set_mode(8'h0A);
    pulse_clr(0);
    pulses0 = 0;
    wdt_tick = 1; cyc(1023);
    check("R4", pulses0, 0, "no pulse before 1024 ticks");
    cyc(1);
    check("R4", wdt_reset, 1, "pulse after 1024 ticks");
    wdt_tick = 0;

    // R10: disabled vs forced
    cur_req = "R10";
    set_mode(8'h88);
    pulse_clr(0);
    pulses0 = 0; pulses1 = 0;
    wdt_tick = 1; cyc(600); wdt_tick = 0; cyc(2);
    check("R10", pulses0, 0, "disabled watchdog never pulses");
    check("R10", pulses1, 2, "forced watchdog pulses");

    // R2: mixed pseudo-random traffic against the model
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mode_wr    = (lfsr[9:4] == 6'd0);
      mode_wdata = {lfsr[15], lfsr[14], lfsr[13], lfsr[12], lfsr[11], lfsr[2:0]};
      cnt_wr     = (lfsr[15:10] == 6'd5);
      cnt_wdata  = lfsr[7:0];
      clr_wdt    = (lfsr[12:6] == 7'd3);
      sleep_req  = (lfsr[13:7] == 7'd9);
      wdt_tick   = lfsr[1] | lfsr[3];
      if (lfsr[5:3] == 3'd0) ext_pin = ~ext_pin;
      cyc(1);
    end
    mode_wr = 0; cnt_wr = 0; clr_wdt = 0; sleep_req = 0; wdt_tick = 0;
    cyc(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule